// File: doc/BRIEF.md
# Six-Channel Output Gating and Diagnostic Pin Logic

This block decides, cycle by cycle, whether each of six power channels is driven, and it produces one parallel diagnostic pin per channel. Each channel's request is formed from a dedicated parallel input and a bit written over the serial port. A single mode select chooses whether the two are ANDed or ORed. A global enable input and the reset input can switch every channel off at once.

Each channel has its own thermal shutdown. A common select picks between two behaviours. In autorestart mode the channel comes back on when the overtemperature clears. In latching mode the channel stays off until its request is re-armed by a fresh rising edge.

Fault indications pass through a per-channel persistence filter that counts microsecond ticks. Overload and overtemperature are qualified only while the channel is commanded on, and open-load or bypass only while it is commanded off. Each diagnostic pin normally follows its channel request and inverts that request while a filtered fault is present. The last pin can instead act as a combined overtemperature flag.

Top module: `chan_drive_diag`

## Requirements
- R1: A channel's request is `par_i[k] | spi_i[k]` when `and_sel_i` is 0 and `par_i[k] & spi_i[k]` when `and_sel_i` is 1. With no faults, `drive_o[k]` equals that request.
- R2: While `all_en_i` is low, every bit of `drive_o` is 0.
- R3: While `rst_n` is low, `drive_o` and `diag_o` are all 0. Reset clears every fault filter, so after release each diagnostic pin follows its request.
- R4: In the same cycle that `ovt_i[k]` is high, `drive_o[k]` is 0.
- R5: With `latch_sel_i` = 0, a channel whose request stays high drives again in the same cycle that its `ovt_i` falls.
- R6: With `latch_sel_i` = 1, an overtemperature seen while the channel is commanded on keeps it off after `ovt_i` clears. It stays off until the request goes low and then high again, and it drives in the cycle of that new rising request.
- R7: `diag_o[k]` equals the channel request while no filtered fault is present. It equals the inverted request once the fault has been present for `FILT_US` ticks. It returns to the request by the first clock edge after the fault disappears.
- R8: `ovl_i` and `ovt_i` count as faults only while the channel is commanded on (request and `all_en_i`), and `opl_i` only while it is commanded off. A change of commanded state restarts the filter.
- R9: The filter advances only on clock edges where `us_tick_i` is 1. Any cycle without the fault restarts it from zero, so shorter faults give no indication.
- R10: With `diag6_flag_i` = 0, the last diagnostic pin behaves like the others. With `diag6_flag_i` = 1, it is low whenever `ic_ovt_i` is high or any channel's overtemperature flag is set, and high otherwise.
- R11: A channel's overtemperature flag is set one clock edge after its filter reaches the limit with `ovt_i` high while the channel is commanded on. The flag stays set after the fault clears, and only a commanded off-then-on sequence clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces all outputs off |
| all_en_i | input | 1 | Global enable; low switches all channels off |
| and_sel_i | input | 1 | Combine mode: 0 = OR, 1 = AND |
| latch_sel_i | input | 1 | Thermal shutdown: 0 = autorestart, 1 = latch until new rising request |
| diag6_flag_i | input | 1 | Last diagnostic pin function: 0 = channel diagnostic, 1 = overtemperature flag |
| us_tick_i | input | 1 | One-cycle pulse per microsecond for the fault filters |
| par_i | input | NCH | Parallel channel requests, active high |
| spi_i | input | NCH | Serially written channel bits, active high |
| ovt_i | input | NCH | Per-channel overtemperature indication |
| ovl_i | input | NCH | Per-channel overload indication |
| opl_i | input | NCH | Per-channel open-load or switch-bypass indication |
| ic_ovt_i | input | 1 | Die overtemperature indication |
| drive_o | output | NCH | Per-channel drive request to the power stage |
| diag_o | output | NCH | Parallel diagnostic pins |

## Verification
The bench sweeps every pairing of parallel and serial bits under both combine modes, with the global enable both high and low. Swapped AND/OR polarity or a missing enable gate would show up on the very first patterns.

Directed sequences go after the timing corners:
- Latching mode must keep a channel dark after the overtemperature clears, yet turn it on in the very cycle of a new rising request. A design that re-arms one cycle late, or re-arms on level, fails here.
- A filter that keeps counting through a gap, or counts without a tick, would raise the diagnostic early.
- A design that evaluates open load while on, or overload while off, would invert a pin that must stay quiet.
- A flag that is cleared when the fault disappears, rather than by an off-then-on cycle, would release the combined pin too soon.

// File: rtl/chan_drive_pkg.sv
package chan_drive_pkg;

    // Registered per-channel state of the gating logic
    typedef struct packed {
        logic req_prev;   // request seen at the previous edge
        logic on_prev;    // commanded-on state at the previous edge
        logic locked;     // thermal latch, only meaningful in latching mode
        logic ovt_flag;   // sticky channel overtemperature flag
    } chan_st_t;

endpackage

// File: rtl/chan_fault_filter.sv
module chan_fault_filter #(
    parameter int unsigned LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fault_i,
    input  logic restart_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!fault_i || restart_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
        filt_o = (cnt_q == LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R9
    cnt_holds_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && !tick_i && !restart_i) |=> $stable(cnt_q));

    // R7
    cnt_clears_on_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_i |=> (cnt_q == '0));

endmodule

// File: rtl/chan_ctl.sv
module chan_ctl
    import chan_drive_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic par_i,
    input  logic spi_i,
    input  logic and_sel_i,
    input  logic all_en_i,
    input  logic latch_sel_i,
    input  logic ovt_i,
    input  logic ovl_i,
    input  logic opl_i,
    input  logic filt_i,
    output logic drive_o,
    output logic diag_o,
    output logic fault_o,
    output logic restart_o,
    output logic ovt_flag_o
);
    chan_st_t st_d, st_q;
    logic req, on, rise, cand;

    always_comb begin
        req  = and_sel_i ? (par_i & spi_i) : (par_i | spi_i);
        on   = req & all_en_i;
        rise = req & ~st_q.req_prev;
        cand = on & (~(st_q.locked & latch_sel_i) | rise);

        drive_o    = rst_n & cand & ~ovt_i;
        fault_o    = on ? (ovt_i | ovl_i) : opl_i;
        restart_o  = on ^ st_q.on_prev;
        diag_o     = rst_n & (filt_i ? ~req : req);
        ovt_flag_o = st_q.ovt_flag;

        st_d          = st_q;
        st_d.req_prev = req;
        st_d.on_prev  = on;

        if (!latch_sel_i)        st_d.locked = 1'b0;
        else if (cand && ovt_i)  st_d.locked = 1'b1;
        else if (rise)           st_d.locked = 1'b0;

        if (on && !st_q.on_prev)           st_d.ovt_flag = 1'b0;
        else if (filt_i && ovt_i && on)    st_d.ovt_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    ovt_cuts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovt_i |-> !drive_o);

    // R6
    latched_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_sel_i && st_q.locked && !rise) |-> !drive_o);

    // R11
    flag_needs_hot_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovt_flag) |-> $past(ovt_i && on && filt_i));

endmodule

// File: rtl/chan_drive_diag.sv
module chan_drive_diag #(
    parameter int unsigned NCH     = 6,
    parameter int unsigned FILT_US = 200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           all_en_i,
    input  logic           and_sel_i,
    input  logic           latch_sel_i,
    input  logic           diag6_flag_i,
    input  logic           us_tick_i,
    input  logic [NCH-1:0] par_i,
    input  logic [NCH-1:0] spi_i,
    input  logic [NCH-1:0] ovt_i,
    input  logic [NCH-1:0] ovl_i,
    input  logic [NCH-1:0] opl_i,
    input  logic           ic_ovt_i,
    output logic [NCH-1:0] drive_o,
    output logic [NCH-1:0] diag_o
);
    localparam int unsigned LAST = NCH - 1;

    logic [NCH-1:0] diag_ch, fault, restart, filt, ovt_flag;
    logic           flag_pin;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        chan_ctl u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .par_i      (par_i[k]),
            .spi_i      (spi_i[k]),
            .and_sel_i  (and_sel_i),
            .all_en_i   (all_en_i),
            .latch_sel_i(latch_sel_i),
            .ovt_i      (ovt_i[k]),
            .ovl_i      (ovl_i[k]),
            .opl_i      (opl_i[k]),
            .filt_i     (filt[k]),
            .drive_o    (drive_o[k]),
            .diag_o     (diag_ch[k]),
            .fault_o    (fault[k]),
            .restart_o  (restart[k]),
            .ovt_flag_o (ovt_flag[k])
        );

        chan_fault_filter #(.LIMIT(FILT_US)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (us_tick_i),
            .fault_i  (fault[k]),
            .restart_i(restart[k]),
            .filt_o   (filt[k])
        );
    end

    always_comb begin
        flag_pin = rst_n & ~(ic_ovt_i | (|ovt_flag));
        diag_o   = diag_ch;
        if (diag6_flag_i) diag_o[LAST] = flag_pin;
    end

    // R2
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_en_i |-> (drive_o == '0));

    // R10
    die_hot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diag6_flag_i && ic_ovt_i) |-> !diag_o[LAST]);

endmodule

// File: tb/chan_drive_diag_bench.sv
`timescale 1ns/100ps
module chan_drive_diag_bench;
    localparam int NCH  = 6;
    localparam int FILT = 3;

    logic clk = 1'b0;
    logic rst_n, all_en, and_sel, latch_sel, flag_sel, tick, ic_ovt;
    logic [NCH-1:0] par, spi, ovt, ovl, opl, drive, diag;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chan_drive_diag #(.NCH(NCH), .FILT_US(FILT)) u_chan_drive_diag (
        .clk(clk), .rst_n(rst_n), .all_en_i(all_en), .and_sel_i(and_sel),
        .latch_sel_i(latch_sel), .diag6_flag_i(flag_sel), .us_tick_i(tick),
        .par_i(par), .spi_i(spi), .ovt_i(ovt), .ovl_i(ovl), .opl_i(opl),
        .ic_ovt_i(ic_ovt), .drive_o(drive), .diag_o(diag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [NCH-1:0] req_e;
        rst_n = 0; all_en = 1; and_sel = 0; latch_sel = 0; flag_sel = 0;
        tick = 1; ic_ovt = 0; par = '1; spi = '0; ovt = '0; ovl = '0; opl = '0;
        edges(2);
        // R3 reset state
        check("R3 drive in reset", 32'(drive), 0);
        check("R3 diag in reset", 32'(diag), 0);
        rst_n = 1; #1;
        check("R3 drive after release", 32'(drive), 32'h3F);
        check("R3 diag after release", 32'(diag), 32'h3F);

        // R1 R2 exhaustive combine sweep, no faults
        @(negedge clk); #0.5;
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 2; e++)
                for (int p = 0; p < 64; p++)
                    for (int s = 0; s < 64; s++) begin
                        and_sel = m[0]; all_en = e[0]; par = 6'(p); spi = 6'(s);
                        #1;
                        req_e = m[0] ? 6'(p & s) : 6'(p | s);
                        if (e[0]) check("R1 drive combine", 32'(drive), 32'(req_e));
                        else      check("R2 drive disabled", 32'(drive), 0);
                        check("R1 diag follows request", 32'(diag), 32'(req_e));
                    end
        and_sel = 0; all_en = 1; par = '0; spi = '0;
        edges(2);

        // R4 R5 autorestart on channel 0
        latch_sel = 0; par = 6'b000001; edges(1);
        ovt[0] = 1; #1;
        check("R4 ovt cuts drive", 32'(drive[0]), 0);
        edges(2);
        check("R4 still off while hot", 32'(drive[0]), 0);
        ovt[0] = 0; #1;
        check("R5 autorestart", 32'(drive[0]), 1);

        // R6 latching on channel 1
        latch_sel = 1; par = 6'b000010; edges(1);
        ovt[1] = 1; #1;
        check("R6 hot off", 32'(drive[1]), 0);
        edges(1);
        ovt[1] = 0; #1;
        check("R6 stays off after cool", 32'(drive[1]), 0);
        edges(3);
        check("R6 stays off later", 32'(drive[1]), 0);
        par[1] = 0; edges(1);
        par[1] = 1; #1;
        check("R6 rearm on rising request", 32'(drive[1]), 1);
        edges(2);
        check("R6 on after rearm", 32'(drive[1]), 1);
        latch_sel = 0;

        // R7 filter on channel 2
        par = 6'b000100; edges(1);
        ovl[2] = 1; edges(2);
        check("R7 not yet filtered", 32'(diag[2]), 1);
        edges(1);
        check("R7 filtered inverts", 32'(diag[2]), 0);
        ovl[2] = 0; edges(1);
        check("R7 follows after fault gone", 32'(diag[2]), 1);

        // R9 tick gating and restart
        tick = 0; ovl[2] = 1; edges(5);
        check("R9 no count without tick", 32'(diag[2]), 1);
        tick = 1; edges(2);
        ovl[2] = 0; edges(1);
        ovl[2] = 1; edges(2);
        check("R9 gap restarts filter", 32'(diag[2]), 1);
        edges(1);
        check("R9 filtered after full run", 32'(diag[2]), 0);

        // R3 reset clears the filter
        ovl[2] = 0; rst_n = 0; #1;
        check("R3 diag forced low", 32'(diag), 0);
        edges(1);
        rst_n = 1; #1;
        check("R3 filter cleared", 32'(diag[2]), 1);

        // R8 qualification by commanded state on channel 3
        par = '0; edges(1);
        ovl[3] = 1; edges(4);
        check("R8 overload ignored when off", 32'(diag[3]), 0);
        ovl[3] = 0; opl[3] = 1; edges(3);
        check("R8 open load seen when off", 32'(diag[3]), 1);
        par[3] = 1; edges(4);
        check("R8 open load ignored when on", 32'(diag[3]), 1);
        opl[3] = 0; par = '0; edges(1);

        // R10 R11 combined overtemperature pin
        flag_sel = 1; #1;
        check("R10 flag idle high", 32'(diag[5]), 1);
        ic_ovt = 1; #1;
        check("R10 die hot pulls low", 32'(diag[5]), 0);
        ic_ovt = 0; #1;
        check("R10 die cool releases", 32'(diag[5]), 1);
        par = 6'b010000; edges(1);
        ovt[4] = 1; edges(3);
        check("R11 channel filtered", 32'(diag[4]), 0);
        check("R11 flag not yet set", 32'(diag[5]), 1);
        edges(1);
        check("R11 flag set", 32'(diag[5]), 0);
        ovt[4] = 0; edges(2);
        check("R11 flag sticky", 32'(diag[5]), 0);
        check("R11 channel diag recovers", 32'(diag[4]), 1);
        par = '0; edges(1);
        par = 6'b010000; edges(1);
        check("R11 off-on clears flag", 32'(diag[5]), 1);
        flag_sel = 0; par = 6'b100000; #1;
        check("R10 plain diag high", 32'(diag[5]), 1);
        par = '0; #1;
        check("R10 plain diag low", 32'(diag[5]), 0);

        done = 1'b1;
        summary();
    end
endmodule